// File: doc/BRIEF.md
# Rotate and Field-Mask Generator

This unit serves the shift and bit-field operations of a 16-bit datapath. In one transaction it takes a data word, a left-rotate amount and a mask-width code. One clock later it returns two results: the word rotated left by that amount, and a mask made of one contiguous run of ones. A mode input sets where the run of ones sits. In right-justified mode the run starts at bit 0. In left-justified mode the run ends at the top bit. The rotate result and the mask result never depend on each other, so a caller can take either one on its own.

Inside, the rotation runs in two stages. A coarse stage rotates by a multiple of four positions. A fine stage then corrects by -1, 0, +1 or +2 positions. The mask comes from a computed table of right-justified masks. In left-justified mode the unit reads a table entry, complements it, shifts it right by one position and sets the vacated top bit to 1.

A two-state output controller holds the result registers. EMPTY is the reset state, and out_valid is low in it. FULL means the registers hold a result captured on the previous edge, and out_valid is high. There are four transitions. EMPTY goes to FULL when in_valid is high. FULL stays in FULL when in_valid is high. FULL goes back to EMPTY when in_valid is low. EMPTY stays in EMPTY when in_valid is low.

Top module: `rmg_unit`

## Requirements
- R1: While rst_n is low and after it is released, and before the first in_valid, out_valid is 0 and rot_out and mask_out are 0x0000.
- R2: out_valid is 1 in exactly the cycle after each cycle in which in_valid was 1 at the clock edge, and 0 otherwise.
- R3: rot_out is data_in rotated left by rot_amt positions (0..15), where bit j moves to bit (j+rot_amt) mod 16. A rot_amt of 0 returns data_in unchanged.
- R4: When mask_left is 0, a mask_code of k gives k+1 ones in bits 0..k and zeros above them. Code 0 gives 0x0001, code 7 gives 0x00FF and code 15 gives 0xFFFF.
- R5: When mask_left is 1, mask_code is read as a count n of ones placed in bits 15 down to 16-n, with n = 0 standing for sixteen. So 1 gives 0x8000, 8 gives 0xFF00, 15 gives 0xFFFE and 0 gives 0xFFFF.
- R6: In a cycle where in_valid is 0 at the edge, rot_out and mask_out keep their previous values, whatever the other inputs do.
- R7: rot_out does not depend on mask_code or mask_left, and mask_out does not depend on data_in or rot_amt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe that captures the operands on this edge |
| data_in | input | 16 | Word to rotate |
| rot_amt | input | 4 | Left-rotate amount |
| mask_code | input | 4 | Width code: k+1 ones in right mode, count n (0 = 16) in left mode |
| mask_left | input | 1 | 1 selects a left-justified mask, 0 a right-justified mask |
| out_valid | output | 1 | High the cycle after a captured strobe |
| rot_out | output | 16 | Registered rotated word |
| mask_out | output | 16 | Registered mask |

## Verification
A hand-written vector table pins down named values. These include a rotate of 0 passing the word through, rotate amounts at each fine offset (-1, 0, +1, +2) inside several coarse groups, and the wrap case of 15. Asymmetric data words are used so that a rotate in the wrong direction or by the wrong step gives a different word. A sweep then covers every rotate amount against every code in both mask modes. This tells apart faults in coarse-group selection, in the fine-offset selection and in the count-to-index mapping of the left-justified mask, including the n = 0 and n = 1 ends. Directed tests change the operands while in_valid is low to show that the results are held. They also reuse one data word under different mask settings, and one mask setting under different data, to show that the two result paths are independent.

// File: rtl/rmg_pkg.sv
package rmg_pkg;

    typedef enum logic {
        OUT_EMPTY = 1'b0,
        OUT_FULL  = 1'b1
    } out_state_e;

endpackage

// File: rtl/rmg_rotator.sv
module rmg_rotator #(
    parameter int W    = 16,
    parameter int GRAN = 4
) (
    input  logic [W-1:0]         data_i,
    input  logic [$clog2(W)-1:0] amt_i,
    output logic [W-1:0]         rot_o
);
    localparam int SHW   = $clog2(W);
    localparam int GSH   = $clog2(GRAN);
    localparam int NGRP  = W / GRAN;

    function automatic logic [W-1:0] rotl(input logic [W-1:0] x, input int s);
        logic [W-1:0] y;
        for (int j = 0; j < W; j++) begin
            y[j] = x[(j - s + W) % W];
        end
        return y;
    endfunction

    // amount+1 splits into a coarse group (upper bits, wraps mod W) and
    // a fine index (lower bits) meaning an offset of index-1.
    logic [SHW-1:0] amt_p1;
    logic [SHW-GSH-1:0] grp_sel;
    logic [GSH-1:0] fine_sel;

    assign amt_p1   = amt_i + 1'b1;
    assign grp_sel  = amt_p1[SHW-1:GSH];
    assign fine_sel = amt_p1[GSH-1:0];

    logic [W-1:0] coarse_cand [NGRP];
    logic [W-1:0] fine_cand   [GRAN];
    logic [W-1:0] coarse_rot;

    for (genvar g = 0; g < NGRP; g++) begin : g_coarse
        assign coarse_cand[g] = rotl(data_i, g * GRAN);
    end

    assign coarse_rot = coarse_cand[grp_sel];

    for (genvar f = 0; f < GRAN; f++) begin : g_fine
        assign fine_cand[f] = rotl(coarse_rot, (f - 1 + W) % W);
    end

    assign rot_o = fine_cand[fine_sel];

endmodule

// File: rtl/rmg_mask_gen.sv
module rmg_mask_gen #(
    parameter int W = 16
) (
    input  logic [$clog2(W)-1:0] code_i,
    input  logic                 left_i,
    output logic [W-1:0]         mask_o
);
    localparam int SHW = $clog2(W);

    logic [W-1:0] rj_tbl [W];

    for (genvar i = 0; i < W; i++) begin : g_row
        for (genvar j = 0; j < W; j++) begin : g_bit
            assign rj_tbl[i][j] = (j <= i) ? 1'b1 : 1'b0;
        end
    end

    logic [SHW-1:0] idx;
    logic [W-1:0]   rj_mask;

    // Left mode: count n indexes entry (-n mod W), which holds W+1-n ones;
    // complement, shift right, fill top with one -> n ones at the top.
    assign idx     = left_i ? (SHW'(0) - code_i) : code_i;
    assign rj_mask = rj_tbl[idx];

    always_comb begin
        if (left_i) begin
            mask_o = {1'b1, ~rj_mask[W-1:1]};
        end else begin
            mask_o = rj_mask;
        end
    end

endmodule

// File: rtl/rmg_unit.sv
module rmg_unit #(
    parameter int W    = 16,
    parameter int GRAN = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [W-1:0]         data_in,
    input  logic [$clog2(W)-1:0] rot_amt,
    input  logic [$clog2(W)-1:0] mask_code,
    input  logic                 mask_left,
    output logic                 out_valid,
    output logic [W-1:0]         rot_out,
    output logic [W-1:0]         mask_out
);
    import rmg_pkg::*;

    out_state_e   state_q, state_d;
    logic [W-1:0] rot_c, mask_c;

    rmg_rotator #(.W(W), .GRAN(GRAN)) u_rot (
        .data_i (data_in),
        .amt_i  (rot_amt),
        .rot_o  (rot_c)
    );

    rmg_mask_gen #(.W(W)) u_mask (
        .code_i (mask_code),
        .left_i (mask_left),
        .mask_o (mask_c)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_EMPTY: state_d = in_valid ? OUT_FULL : OUT_EMPTY;
            OUT_FULL:  state_d = in_valid ? OUT_FULL : OUT_EMPTY;
            default:   state_d = OUT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OUT_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rot_out  <= '0;
            mask_out <= '0;
        end else if (in_valid) begin
            rot_out  <= rot_c;
            mask_out <= mask_c;
        end
    end

    assign out_valid = (state_q == OUT_FULL);

endmodule

// File: rtl/rmg_unit_chk.sv
module rmg_unit_chk #(
    parameter int W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [W-1:0]         data_in,
    input logic [$clog2(W)-1:0] mask_code,
    input logic                 mask_left,
    input logic                 out_valid,
    input logic [W-1:0]         rot_out,
    input logic [W-1:0]         mask_out
);
    p_valid_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_no_valid_without_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(rot_out) && $stable(mask_out)));

    p_rot_keeps_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ($countones(rot_out) == $countones($past(data_in))));

    p_right_mask_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mask_left) |=>
            (mask_out[0] && ($countones(mask_out) == 32'($past(mask_code)) + 1)));

    p_left_mask_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_left) |=>
            (mask_out[W-1] && ($countones(mask_out) ==
                (($past(mask_code) == '0) ? W : 32'($past(mask_code))))));

endmodule

bind rmg_unit rmg_unit_chk #(.W(W)) u_rmg_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .data_in   (data_in),
    .mask_code (mask_code),
    .mask_left (mask_left),
    .out_valid (out_valid),
    .rot_out   (rot_out),
    .mask_out  (mask_out)
);

// File: tb/test_rmg_unit.sv
module test_rmg_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] data_in = '0;
    logic [3:0]  rot_amt = '0;
    logic [3:0]  mask_code = '0;
    logic        mask_left = 1'b0;
    logic        out_valid;
    logic [15:0] rot_out;
    logic [15:0] mask_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rmg_unit i_rmg_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .data_in   (data_in),
        .rot_amt   (rot_amt),
        .mask_code (mask_code),
        .mask_left (mask_left),
        .out_valid (out_valid),
        .rot_out   (rot_out),
        .mask_out  (mask_out)
    );

    typedef struct packed {
        logic [15:0] d;
        logic [3:0]  r;
        logic [3:0]  k;
        logic        lj;
        logic [15:0] er;
        logic [15:0] em;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{16'h1234, 4'd0,  4'd0,  1'b0, 16'h1234, 16'h0001},
        '{16'h1234, 4'd4,  4'd7,  1'b0, 16'h2341, 16'h00FF},
        '{16'h8001, 4'd1,  4'd15, 1'b0, 16'h0003, 16'hFFFF},
        '{16'h8001, 4'd15, 4'd0,  1'b1, 16'hC000, 16'hFFFF},
        '{16'h00F0, 4'd3,  4'd1,  1'b1, 16'h0780, 16'h8000},
        '{16'hA5C3, 4'd8,  4'd8,  1'b1, 16'hC3A5, 16'hFF00},
        '{16'h0001, 4'd2,  4'd3,  1'b0, 16'h0004, 16'h000F},
        '{16'h0001, 4'd7,  4'd4,  1'b1, 16'h0080, 16'hF000},
        '{16'h4000, 4'd5,  4'd11, 1'b0, 16'h0008, 16'h0FFF},
        '{16'hF00F, 4'd6,  4'd15, 1'b1, 16'h03FC, 16'hFFFE},
        '{16'h1234, 4'd12, 4'd14, 1'b0, 16'h4123, 16'h7FFF}
    };

    function automatic logic [15:0] ref_rot(input logic [15:0] x, input int r);
        logic [15:0] y = x;
        for (int i = 0; i < r; i++) y = {y[14:0], y[15]};
        return y;
    endfunction

    function automatic logic [15:0] ref_mask(input int k, input bit lj);
        logic [15:0] m = '0;
        int n;
        if (!lj) begin
            for (int i = 0; i <= k; i++) m[i] = 1'b1;
        end else begin
            n = (k == 0) ? 16 : k;
            for (int i = 0; i < n; i++) m[15 - i] = 1'b1;
        end
        return m;
    endfunction

    task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Drive one strobe; return at the negedge after the capturing edge.
    task automatic issue(input logic [15:0] d, input logic [3:0] r,
                         input logic [3:0] k, input logic lj);
        @(negedge clk);
        data_in = d; rot_amt = r; mask_code = k; mask_left = lj;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [15:0] held_r, held_m;

        // R1: reset state
        repeat (3) @(negedge clk);
        check1("R1 valid in reset", out_valid, 1'b0);
        check16("R1 rot in reset", rot_out, 16'h0000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check1("R1 valid after release", out_valid, 1'b0);
        check16("R1 mask after release", mask_out, 16'h0000);

        // Table walk: R3, R4, R5, R2
        for (int v = 0; v < NV; v++) begin
            issue(VECS[v].d, VECS[v].r, VECS[v].k, VECS[v].lj);
            check1("R2 valid after strobe", out_valid, 1'b1);
            check16("R3 rotate vector", rot_out, VECS[v].er);
            check16(VECS[v].lj ? "R5 left mask vector" : "R4 right mask vector",
                    mask_out, VECS[v].em);
        end

        // R2/R6: idle cycle with changing operands holds the result
        held_r = rot_out; held_m = mask_out;
        data_in = 16'hDEAD; rot_amt = 4'd9; mask_code = 4'd2; mask_left = 1'b0;
        @(negedge clk);
        check1("R2 valid drops when idle", out_valid, 1'b0);
        check16("R6 rot held", rot_out, held_r);
        check16("R6 mask held", mask_out, held_m);

        // R2: back-to-back strobes keep out_valid high
        @(negedge clk);
        data_in = 16'h0F00; rot_amt = 4'd1; mask_code = 4'd5; mask_left = 1'b0;
        in_valid = 1'b1;
        @(negedge clk);
        check1("R2 valid first of pair", out_valid, 1'b1);
        check16("R3 first of pair", rot_out, 16'h1E00);
        data_in = 16'h0F00; rot_amt = 4'd2; mask_code = 4'd5; mask_left = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check1("R2 valid second of pair", out_valid, 1'b1);
        check16("R3 second of pair", rot_out, 16'h3C00);
        check16("R5 second of pair", mask_out, 16'hF800);

        // R7: same data/rotate, different mask settings -> same rot_out
        issue(16'h9C31, 4'd10, 4'd0, 1'b0);
        held_r = rot_out;
        issue(16'h9C31, 4'd10, 4'd13, 1'b1);
        check16("R7 rot unaffected by mask inputs", rot_out, held_r);
        // R7: same mask settings, different data/rotate -> same mask_out
        held_m = mask_out;
        issue(16'h0000, 4'd3, 4'd13, 1'b1);
        check16("R7 mask unaffected by data", mask_out, held_m);

        // Full sweep: R3, R4, R5
        for (int r = 0; r < 16; r++) begin
            for (int k = 0; k < 16; k++) begin
                for (int lj = 0; lj < 2; lj++) begin
                    logic [15:0] d;
                    d = 16'hB38E ^ 16'(r * 16'h1111) ^ 16'(k << 3);
                    issue(d, 4'(r), 4'(k), lj[0]);
                    check16("R3 sweep rotate", rot_out, ref_rot(d, r));
                    check16(lj != 0 ? "R5 sweep mask" : "R4 sweep mask",
                            mask_out, ref_mask(k, lj[0]));
                end
            end
        end

        // R1: reset mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check1("R1 valid on re-reset", out_valid, 1'b0);
        check16("R1 rot on re-reset", rot_out, 16'h0000);
        check16("R1 mask on re-reset", mask_out, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end

endmodule